// File: doc/BRIEF.md
# In-Place Vector Slide Sequencer

This block runs the four vector slide operations (slide by an offset toward higher element indices, slide by an offset toward lower indices, shift up by one with a scalar inserted at element 0, and shift down by one with a scalar inserted at the top element). It works on a private register file of 32 registers with 4 elements each. Registers are grouped by a power-of-two grouping factor (1, 2, 4 or 8), so one operand is a group of consecutive registers that starts at an aligned base. The sequencer handles one element per two cycles: a read cycle, then a write cycle.

The direction of travel through the elements depends on the operation. Operations that move data toward lower indices walk upward from element 0. Operations that move data toward higher indices walk downward from the last active element. With this order, every source element is read before any write can reach it, so the downward slide and both shift-by-one forms may use the same group as source and destination. Before any element moves, the sequencer checks the register operands against rules that depend on the operation. An instruction that breaks a rule ends at once with an illegal flag and writes nothing.

Every element write appears on the write observation port. This makes the result visible, and it is how a scalar-fed vector is built one value at a time.

Top module: `vslide_inplace`

## Requirements
- R1: Encodings: `op` is 0 for offset slide-up, 1 for offset slide-down, 2 for shift-up-by-one and 3 for shift-down-by-one. `lmul` code k selects a group of 2^k registers. Element i of the group with base b has flat address 4*b+i. Each element write shows `wr_en` high, `wr_addr` = 4*`vd`+i and the written value on `wr_data`. Writes never leave the destination group.
- R2: If `vd` or `vs` is not a multiple of the group size, the instruction is illegal, whatever the opcode.
- R3: An offset slide-up is illegal if the destination group [vd, vd+size-1] intersects the source group or contains `vm`.
- R4: For opcodes 1, 2 and 3 the destination may equal or overlap the source. The instruction is illegal only when the destination group contains `vm` and the group size is greater than 1. With a group size of 1, `vm` inside the destination is legal.
- R5: An illegal instruction raises `done` and `illegal` together for exactly one cycle, the cycle after `start` is sampled, and makes no element write.
- R6: Offset slide-up writes destination element i with source element i-offset, for i from the effective length minus 1 down to offset, in descending order. Elements below the offset are not written.
- R7: Offset slide-down writes elements 0 up to the effective length minus 1 in ascending order. Element i takes source element i+offset, or zero when i+offset is at or beyond the group capacity (4 times the group size).
- R8: Shift-up-by-one writes the elements in descending order. Element i takes source element i-1, and element 0 takes `scalar`.
- R9: Shift-down-by-one writes the elements in ascending order. Element i takes source element i+1, and the last active element takes `scalar`.
- R10: When `vd` equals `vs`, opcodes 1, 2 and 3 produce the same values as if the whole source had been read before any write.
- R11: After reset, `done`, `illegal` and `wr_en` are low. Each element takes one read cycle with `wr_en` low, then one write cycle. `done` goes high for one cycle, the cycle after the last write, with `illegal` low.
- R12: The effective length is `vl` clamped to the group capacity. An effective length of zero, or an offset slide-up whose offset is at or beyond the effective length, raises `done` in the cycle after `start` with no writes.
- R13: A `start` pulse that arrives while an operation is in progress is ignored. The running operation's writes do not change, and no extra writes or `done` follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the register file |
| start_i | input | 1 | Starts an instruction when the sequencer is idle |
| op_i | input | 2 | Opcode (see R1) |
| vd_i | input | 5 | Destination group base register |
| vs_i | input | 5 | Source group base register |
| vm_i | input | 5 | Mask register index |
| lmul_i | input | 2 | Group size code, size = 2^code |
| offset_i | input | 6 | Slide offset for opcodes 0 and 1 |
| vl_i | input | 6 | Requested vector length in elements |
| scalar_i | input | 16 | Value inserted by opcodes 2 and 3 |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | High with done when the instruction is rejected |
| wr_en_o | output | 1 | Element write strobe |
| wr_addr_o | output | 7 | Flat element address being written |
| wr_data_o | output | 16 | Element value being written |

## Verification
The assertions watch four things on every cycle. `done` never lasts two cycles. `illegal` only appears together with `done`. A start that the legality check rejects is followed by that response in the next cycle. Every write stays in the destination group and moves one address at a time, in the direction set by the opcode. The element values themselves can only be shown by the bench's scenarios, because they depend on earlier contents. These values include the zero fill past capacity, the scalar insertion point, the untouched elements below the offset, and the in-place results that a wrong traversal order would corrupt. The bench compares these against a model that takes a snapshot of the source before each operation.

// File: rtl/vslide_pkg.sv
package vslide_pkg;

    typedef enum logic [1:0] {
        OP_UP    = 2'd0,
        OP_DOWN  = 2'd1,
        OP_UP1   = 2'd2,
        OP_DOWN1 = 2'd3
    } slide_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    function automatic logic walks_down(slide_op_e op);
        return (op == OP_UP) || (op == OP_UP1);
    endfunction

endpackage

// File: rtl/vslide_legal.sv
module vslide_legal
    import vslide_pkg::*;
#(
    parameter int RW = 5
) (
    input  slide_op_e        op_i,
    input  logic [RW-1:0]    vd_i,
    input  logic [RW-1:0]    vs_i,
    input  logic [RW-1:0]    vm_i,
    input  logic [1:0]       lmul_i,
    output logic             illegal_o
);

    logic [RW:0] span;
    logic [RW:0] d_lo, d_hi, s_lo, s_hi, m_x;
    logic        misaligned, hit_src, hit_mask;

    always_comb begin
        span       = (RW+1)'(1) << lmul_i;
        d_lo       = {1'b0, vd_i};
        s_lo       = {1'b0, vs_i};
        m_x        = {1'b0, vm_i};
        d_hi       = d_lo + span - 1'b1;
        s_hi       = s_lo + span - 1'b1;
        misaligned = ((d_lo & (span - 1'b1)) != '0) || ((s_lo & (span - 1'b1)) != '0);
        hit_src    = (d_lo <= s_hi) && (s_lo <= d_hi);
        hit_mask   = (m_x >= d_lo) && (m_x <= d_hi);
        if (op_i == OP_UP) begin
            illegal_o = misaligned || hit_src || hit_mask;
        end else begin
            illegal_o = misaligned || ((lmul_i != 2'd0) && hit_mask);
        end
    end

endmodule

// File: rtl/vslide_elem_rf.sv
module vslide_elem_rf #(
    parameter int EW     = 16,
    parameter int NREG_W = 5,
    parameter int LANE_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [NREG_W+LANE_W-1:0] waddr_i,
    input  logic [EW-1:0]            wdata_i,
    input  logic [NREG_W+LANE_W-1:0] raddr_i,
    output logic [EW-1:0]            rdata_o
);

    localparam int NBANK = 1 << LANE_W;
    localparam int NREG  = 1 << NREG_W;

    logic [EW-1:0] bank_rd [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [EW-1:0] cell_q [NREG];
        logic          bank_we;

        assign bank_we    = we_i && (waddr_i[LANE_W-1:0] == LANE_W'(b));
        assign bank_rd[b] = cell_q[raddr_i[NREG_W+LANE_W-1:LANE_W]];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int r = 0; r < NREG; r++) cell_q[r] <= '0;
            end else if (bank_we) begin
                cell_q[waddr_i[NREG_W+LANE_W-1:LANE_W]] <= wdata_i;
            end
        end
    end

    assign rdata_o = bank_rd[raddr_i[LANE_W-1:0]];

endmodule

// File: rtl/vslide_inplace.sv
module vslide_inplace
    import vslide_pkg::*;
#(
    parameter int EW     = 16,
    parameter int NREG_W = 5,
    parameter int LANE_W = 2,
    parameter int VL_W   = 6,
    parameter int OFF_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [1:0]               op_i,
    input  logic [NREG_W-1:0]        vd_i,
    input  logic [NREG_W-1:0]        vs_i,
    input  logic [NREG_W-1:0]        vm_i,
    input  logic [1:0]               lmul_i,
    input  logic [OFF_W-1:0]         offset_i,
    input  logic [VL_W-1:0]          vl_i,
    input  logic [EW-1:0]            scalar_i,
    output logic                     done_o,
    output logic                     illegal_o,
    output logic                     wr_en_o,
    output logic [NREG_W+LANE_W-1:0] wr_addr_o,
    output logic [EW-1:0]            wr_data_o
);

    localparam int AW     = NREG_W + LANE_W;
    localparam int LANES  = 1 << LANE_W;
    localparam int IDX_W  = LANE_W + 3 + 1;
    localparam int WIDEST = (OFF_W > IDX_W) ? OFF_W : IDX_W;
    localparam int CW     = ((VL_W > WIDEST) ? VL_W : WIDEST) + 2;

    typedef struct packed {
        seq_state_e         st;
        slide_op_e          op;
        logic [NREG_W-1:0]  vd;
        logic [NREG_W-1:0]  vs;
        logic [1:0]         lmul;
        logic [OFF_W-1:0]   off;
        logic [EW-1:0]      sc;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   last;
        logic [IDX_W-1:0]   vle;
        logic [EW-1:0]      hold;
        logic               done;
        logic               ill;
    } seq_t;

    seq_t q, d;

    slide_op_e       op_in;
    logic            leg_ill;
    logic [CW-1:0]   cap_in, vle_in, off_in;
    logic            nothing_to_do;
    logic [CW-1:0]   src_x, cap_q;
    logic            take_scalar, past_cap;
    logic [AW-1:0]   rd_addr;
    logic [EW-1:0]   rd_data, src_val;

    assign op_in = slide_op_e'(op_i);

    vslide_legal #(.RW(NREG_W)) u_legal (
        .op_i      (op_in),
        .vd_i      (vd_i),
        .vs_i      (vs_i),
        .vm_i      (vm_i),
        .lmul_i    (lmul_i),
        .illegal_o (leg_ill)
    );

    vslide_elem_rf #(.EW(EW), .NREG_W(NREG_W), .LANE_W(LANE_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en_o),
        .waddr_i (wr_addr_o),
        .wdata_i (wr_data_o),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    // Length clamp and empty detection for an incoming instruction
    always_comb begin
        cap_in        = CW'(LANES) << lmul_i;
        off_in        = CW'(offset_i);
        vle_in        = (CW'(vl_i) > cap_in) ? cap_in : CW'(vl_i);
        nothing_to_do = (vle_in == '0) || ((op_in == OP_UP) && (off_in >= vle_in));
    end

    // Source element selection for the current element
    always_comb begin
        cap_q       = CW'(LANES) << q.lmul;
        src_x       = '0;
        take_scalar = 1'b0;
        past_cap    = 1'b0;
        unique case (q.op)
            OP_UP:   src_x = CW'(q.idx) - CW'(q.off);
            OP_DOWN: begin
                src_x    = CW'(q.idx) + CW'(q.off);
                past_cap = (src_x >= cap_q);
            end
            OP_UP1: begin
                if (q.idx == '0) take_scalar = 1'b1;
                else             src_x = CW'(q.idx) - 1'b1;
            end
            OP_DOWN1: begin
                if (CW'(q.idx) == CW'(q.vle) - 1'b1) take_scalar = 1'b1;
                else                                  src_x = CW'(q.idx) + 1'b1;
            end
            default: src_x = '0;
        endcase
        rd_addr = (AW'(q.vs) << LANE_W) + AW'(src_x);
        src_val = take_scalar ? q.sc : (past_cap ? '0 : rd_data);
    end

    // Next-state logic
    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.ill  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (leg_ill) begin
                        d.done = 1'b1;
                        d.ill  = 1'b1;
                    end else if (nothing_to_do) begin
                        d.done = 1'b1;
                    end else begin
                        d.st   = ST_READ;
                        d.op   = op_in;
                        d.vd   = vd_i;
                        d.vs   = vs_i;
                        d.lmul = lmul_i;
                        d.off  = offset_i;
                        d.sc   = scalar_i;
                        d.vle  = IDX_W'(vle_in);
                        if (walks_down(op_in)) begin
                            d.idx  = IDX_W'(vle_in - 1'b1);
                            d.last = (op_in == OP_UP) ? IDX_W'(off_in) : '0;
                        end else begin
                            d.idx  = '0;
                            d.last = IDX_W'(vle_in - 1'b1);
                        end
                    end
                end
            end
            ST_READ: begin
                d.hold = src_val;
                d.st   = ST_WRITE;
            end
            ST_WRITE: begin
                if (q.idx == q.last) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.idx = walks_down(q.op) ? q.idx - 1'b1 : q.idx + 1'b1;
                    d.st  = ST_READ;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o    = q.done;
    assign illegal_o = q.ill;
    assign wr_en_o   = (q.st == ST_WRITE);
    assign wr_addr_o = (AW'(q.vd) << LANE_W) + AW'(q.idx);
    assign wr_data_o = q.hold;

    // Checker state: previous write address within the current operation
    logic [AW-1:0] seen_addr_q;
    logic          seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n || q.st == ST_IDLE) begin
            seen_q      <= 1'b0;
            seen_addr_q <= '0;
        end else if (wr_en_o) begin
            seen_q      <= 1'b1;
            seen_addr_q <= wr_addr_o;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o); // R11
    AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (done_o && !wr_en_o)); // R5
    AST_ILLEGAL_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && q.st == ST_IDLE && leg_ill) |=> (done_o && illegal_o && !wr_en_o)); // R5
    AST_WRITE_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ((wr_addr_o >> LANE_W) >= AW'(q.vd)
                     && (wr_addr_o >> LANE_W) < AW'(q.vd) + (AW'(1) << q.lmul))); // R1
    AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && seen_q) |-> (wr_addr_o == (walks_down(q.op) ? seen_addr_q - 1'b1
                                                                 : seen_addr_q + 1'b1))); // R10

endmodule

// File: tb/vslide_inplace_test.sv
module vslide_inplace_test;

    typedef struct {
        bit    we;
        int    addr;
        int    data;
        bit    dn;
        bit    il;
        string tag;
    } rec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_s = 1'b0;
    logic [1:0]  op_s = '0;
    logic [4:0]  vd_s = '0, vs_s = '0, vm_s = '0;
    logic [1:0]  lc_s = '0;
    logic [5:0]  off_s = '0, vl_s = '0;
    logic [15:0] sc_s = '0;
    logic        done, illegal, wr_en;
    logic [6:0]  wr_addr;
    logic [15:0] wr_data;

    int   checks = 0;
    int   errors = 0;
    int   model [128];
    rec_t expq [$];

    always #5 clk = ~clk;

    vslide_inplace uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_s), .op_i(op_s),
        .vd_i(vd_s), .vs_i(vs_s), .vm_i(vm_s), .lmul_i(lc_s),
        .offset_i(off_s), .vl_i(vl_s), .scalar_i(sc_s),
        .done_o(done), .illegal_o(illegal), .wr_en_o(wr_en),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    // Per-cycle comparison against the expected stream
    always @(negedge clk) begin
        rec_t e;
        bit   bad;
        if (rst_n) begin
            if (expq.size() != 0) e = expq.pop_front();
            else e = '{we: 0, addr: 0, data: 0, dn: 0, il: 0, tag: "R13"};
            bad = (wr_en !== e.we) || (done !== e.dn) || (illegal !== e.il)
                  || (e.we && ((wr_addr !== 7'(e.addr)) || (wr_data !== 16'(e.data))));
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL %s: got we=%0b addr=%0d data=%h done=%0b ill=%0b expected we=%0b addr=%0d data=%h done=%0b ill=%0b",
                         e.tag, wr_en, wr_addr, wr_data, done, illegal,
                         e.we, e.addr, 16'(e.data), e.dn, e.il);
            end
        end
    end

    task automatic push(input bit we, input int a, input int v, input bit dn, input bit il, input string tg);
        rec_t r;
        r.we = we; r.addr = a; r.data = v & 16'hFFFF; r.dn = dn; r.il = il; r.tag = tg;
        expq.push_back(r);
    endtask

    task automatic emit(input int a, input int v, input string tg);
        push(0, 0, 0, 0, 0, tg);
        push(1, a, v, 0, 0, tg);
        model[a] = v & 16'hFFFF;
    endtask

    task automatic do_op(input int o, input int vd, input int vs, input int vm, input int lc,
                         input int off, input int vl, input int sc, input string tg,
                         input bit poke = 1'b0);
        int  snap [128];
        int  lm, cap, vle;
        bit  ill, ov_s, ov_m;
        @(posedge clk); #1;
        op_s = 2'(o); vd_s = 5'(vd); vs_s = 5'(vs); vm_s = 5'(vm); lc_s = 2'(lc);
        off_s = 6'(off); vl_s = 6'(vl); sc_s = 16'(sc); start_s = 1'b1;
        @(posedge clk); #1;
        start_s = 1'b0;
        lm   = 1 << lc;
        cap  = 4 * lm;
        vle  = (vl > cap) ? cap : vl;
        ill  = (vd % lm != 0) || (vs % lm != 0);
        ov_s = (vd <= vs + lm - 1) && (vs <= vd + lm - 1);
        ov_m = (vm >= vd) && (vm <= vd + lm - 1);
        if (o == 0) ill = ill || ov_s || ov_m;
        else        ill = ill || (lm > 1 && ov_m);
        for (int k = 0; k < 128; k++) snap[k] = model[k];
        if (ill) begin
            push(0, 0, 0, 1, 1, tg);
        end else begin
            case (o)
                0: for (int i = vle - 1; i >= off; i--) emit(4*vd + i, snap[4*vs + i - off], tg);
                1: for (int i = 0; i < vle; i++)
                       emit(4*vd + i, (i + off < cap) ? snap[4*vs + i + off] : 0, tg);
                2: for (int i = vle - 1; i >= 0; i--)
                       emit(4*vd + i, (i == 0) ? sc : snap[4*vs + i - 1], tg);
                default: for (int i = 0; i < vle; i++)
                       emit(4*vd + i, (i == vle - 1) ? sc : snap[4*vs + i + 1], tg);
            endcase
            push(0, 0, 0, 1, 0, tg);
        end
        if (poke) begin
            repeat (3) @(negedge clk);
            op_s = 2'd3; vd_s = 5'd0; vs_s = 5'd0; vl_s = 6'd4; sc_s = 16'hDEAD; start_s = 1'b1;
            @(posedge clk); #1;
            start_s = 1'b0;
        end
        while (expq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got no completion expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 128; k++) model[k] = 0;
        // R11: reset state
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (done !== 1'b0 || illegal !== 1'b0 || wr_en !== 1'b0) begin
                errors++;
                $display("FAIL R11 reset: got done=%0b ill=%0b we=%0b expected 0 0 0", done, illegal, wr_en);
            end
        end
        rst_n = 1'b1;

        // R9 R10: build v2 with shift-down-by-one in place
        for (int k = 0; k < 4; k++) do_op(3, 2, 2, 0, 0, 0, 4, 16'h0011 * (k + 1), "R9");
        // R9: build group v8..v9
        for (int k = 0; k < 8; k++) do_op(3, 8, 8, 0, 1, 0, 8, 16'h0100 + k, "R9");
        // R8: build group v16..v19 with shift-up-by-one
        for (int k = 0; k < 16; k++) do_op(2, 16, 16, 0, 2, 0, 16, 16'h0200 + 3*k, "R8");
        // R6: slide-up, offsets 3 and 0
        do_op(0, 4, 8, 0, 1, 3, 8, 0, "R6");
        do_op(0, 12, 16, 0, 2, 0, 13, 0, "R6");
        // R7 R10: slide-down in place with zero fill past capacity
        do_op(1, 16, 16, 0, 2, 5, 16, 0, "R10");
        // R8 R10: shift-up-by-one in place, partial length
        do_op(2, 8, 8, 0, 1, 0, 6, 16'hA5A5, "R10");
        // R9 R10: shift-down-by-one in place
        do_op(3, 2, 2, 0, 0, 0, 4, 16'h7E57, "R10");
        // R7: group of eight registers
        do_op(1, 24, 0, 1, 3, 1, 32, 0, "R7");
        // R3: slide-up overlap with source, then with mask
        do_op(0, 8, 8, 0, 1, 1, 8, 0, "R3");
        do_op(0, 4, 8, 5, 1, 1, 8, 0, "R3");
        // R2: misaligned destination and source
        do_op(1, 3, 8, 0, 1, 1, 8, 0, "R2");
        do_op(2, 8, 6, 0, 2, 0, 8, 0, "R2");
        // R4 R5: mask inside destination with group size 2 is illegal
        do_op(1, 8, 8, 9, 1, 1, 8, 0, "R5");
        // R4: mask inside destination with group size 1 is legal
        do_op(1, 2, 2, 2, 0, 1, 4, 0, "R4");
        // R12: empty and clamped lengths
        do_op(3, 20, 20, 0, 0, 0, 0, 16'h1234, "R12");
        do_op(0, 4, 8, 0, 1, 9, 8, 0, "R12");
        do_op(2, 20, 20, 0, 0, 0, 40, 16'h4321, "R12");
        do_op(1, 21, 2, 0, 0, 40, 4, 0, "R7");
        // R13: start while busy is ignored
        do_op(0, 28, 4, 0, 2, 2, 16, 0, "R13", 1'b1);
        repeat (4) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule